// File: doc/BRIEF.md
# Multiplexed-Bus Peripheral Access Bridge

This block lets a system bus with separate address and data paths reach a peripheral that has only one shared address/data bus. The bridge watches every system cycle. It acts only when the cycle-type lines report an I/O cycle and the upper byte of the I/O address equals an 8-bit board address supplied on configuration pins. The lower byte of the I/O address selects the register inside the peripheral.

An accepted cycle runs in two phases on the shared bus. In the first phase the bridge drives the register address and gives a one-clock latch strobe. In the second phase the bridge either drives the write data under a write strobe, or releases the bus under a read strobe and captures what the peripheral returns. The active-low acknowledge to the system bus is asserted only after both phases are complete. It stays asserted until the system drops its request, and then the bridge returns to idle. Each phase length is a parameter counted in system clocks, with a default of 2.

Top module: `mux_bus_bridge`

## Requirements
- R1: A sequence starts only when req_i is high, cyc_type_i equals 2'b10 (I/O cycle) and io_addr_i[15:8] equals board_addr_i, all sampled at one rising clock edge while the bridge is idle.
- R2: For the ADDR_CYC clocks after the start edge, mbus_oe_o is high and mbus_o equals io_addr_i[7:0]. ale_o is high during the first of these clocks only.
- R3: In a write (we_i high), for the DATA_CYC clocks after the address phase, mbus_oe_o is high, mbus_o equals wdata_i and pwr_o is high.
- R4: In a read (we_i low), for the DATA_CYC clocks after the address phase, mbus_oe_o is low and prd_o is high. The value on mbus_i in the last clock of the read strobe appears on rdata_o from the acknowledge onward.
- R5: ack_no goes low ADDR_CYC+DATA_CYC+1 rising edges after the request is first presented. It stays low while req_i stays high, and it returns high one clock after req_i falls.
- R6: A cycle with a non-matching board address or a cycle type other than 2'b10 produces no strobe, no acknowledge and no drive of the shared bus, and it leaves the peripheral's registers unchanged.
- R7: While rst_ni is low, ack_no is high and ale_o, prd_o, pwr_o and mbus_oe_o are low.
- R8: At most one of ale_o, prd_o and pwr_o is high in any clock, and none is high while ack_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| board_addr_i | input | 8 | Configured board I/O address |
| req_i | input | 1 | System cycle active |
| cyc_type_i | input | 2 | Cycle-type lines, 2'b10 = I/O |
| we_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 16 | [15:8] board select, [7:0] peripheral register |
| wdata_i | input | 8 | System write data |
| rdata_o | output | 8 | Read data captured from the peripheral |
| ack_no | output | 1 | Cycle acknowledge, active low |
| mbus_o | output | 8 | Shared bus value when driven |
| mbus_oe_o | output | 1 | Shared bus output enable |
| mbus_i | input | 8 | Shared bus value returned by the peripheral |
| ale_o | output | 1 | Address latch strobe |
| prd_o | output | 1 | Peripheral read strobe |
| pwr_o | output | 1 | Peripheral write strobe |

## Verification
If the phase counter or the state is wrong, the strobe pattern on the shared bus is wrong in the same clock. The bench sees this as a misplaced latch strobe, a data strobe that is too long or too short, or bus drive during a read. It also shows as an acknowledge that arrives on the wrong edge, counted from the request. A wrong latch of the direction or register index shows up later, when the bench reads a register back and gets the wrong value or finds a register it did not write has changed. A decode fault shows within one clock: strobes appear for a foreign cycle, or a valid cycle is never acknowledged.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_ACK  = 2'd3
  } br_state_e;

  localparam logic [1:0] CYC_IO = 2'b10;
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode #(
  parameter int BA_W = 8
) (
  input  logic [BA_W-1:0] board_addr_i,
  input  logic [BA_W-1:0] sel_addr_i,
  input  logic [1:0]      cyc_type_i,
  input  logic            req_i,
  output logic            hit_o
);
  import bridge_pkg::*;

  assign hit_o = req_i && (cyc_type_i == CYC_IO) && (sel_addr_i == board_addr_i);
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int DATA_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hit_i,
  input  logic      req_i,
  output br_state_e state_o,
  output logic      first_o,
  output logic      last_o
);
  localparam int MAXC = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DATA_CYC - 1);

  br_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (hit_i) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (cnt_q == A_LAST) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == D_LAST) begin
            state_q <= ST_ACK;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACK: if (!req_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (state_q == ST_DATA) && (cnt_q == D_LAST);

  // R5
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && !req_i) |=> (state_q == ST_IDLE));

  // R3
  data_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (cnt_q <= D_LAST));
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  br_state_e     state_i,
  input  logic          hit_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic          we_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mbus_i,
  output logic [DW-1:0] mbus_o,
  output logic          mbus_oe_o,
  output logic          ale_o,
  output logic          prd_o,
  output logic          pwr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int BW = (AW > DW) ? AW : DW;

  logic          we_q;
  logic [AW-1:0] reg_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q;
  logic [BW-1:0] bus_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      reg_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (state_i == ST_IDLE && hit_i) begin
        we_q   <= we_i;
        reg_q  <= reg_i;
        wdat_q <= wdata_i;
      end
      // capture at the end of the read strobe
      if (last_i && !we_q) rdat_q <= mbus_i;
    end
  end

  always_comb begin
    bus_w = '0;
    if (state_i == ST_ADDR) bus_w[AW-1:0] = reg_q;
    else                    bus_w[DW-1:0] = wdat_q;
  end

  assign mbus_o    = bus_w[DW-1:0];
  assign mbus_oe_o = (state_i == ST_ADDR) || (state_i == ST_DATA && we_q);
  assign ale_o     = (state_i == ST_ADDR) && first_i;
  assign prd_o     = (state_i == ST_DATA) && !we_q;
  assign pwr_o     = (state_i == ST_DATA) && we_q;
  assign rdata_o   = rdat_q;

  // R4
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_o |-> !mbus_oe_o);

  // R2
  ale_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> mbus_oe_o);

  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ale_o, prd_o, pwr_o}));
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int DATA_CYC = 2,
  parameter int BA_W     = 8,
  parameter int AW       = 8,
  parameter int DW       = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BA_W-1:0]      board_addr_i,
  input  logic                 req_i,
  input  logic [1:0]           cyc_type_i,
  input  logic                 we_i,
  input  logic [BA_W+AW-1:0]   io_addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 ack_no,
  output logic [DW-1:0]        mbus_o,
  output logic                 mbus_oe_o,
  input  logic [DW-1:0]        mbus_i,
  output logic                 ale_o,
  output logic                 prd_o,
  output logic                 pwr_o
);
  br_state_e state;
  logic      req_hit, hit, first, last;

  bridge_decode #(.BA_W(BA_W)) u_decode (
    .board_addr_i (board_addr_i),
    .sel_addr_i   (io_addr_i[BA_W+AW-1:AW]),
    .cyc_type_i   (cyc_type_i),
    .req_i        (req_i),
    .hit_o        (req_hit)
  );

  assign hit = req_hit && (state == ST_IDLE);

  bridge_seq #(.ADDR_CYC(ADDR_CYC), .DATA_CYC(DATA_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .req_i   (req_i),
    .state_o (state),
    .first_o (first),
    .last_o  (last)
  );

  bridge_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .hit_i     (hit),
    .first_i   (first),
    .last_i    (last),
    .we_i      (we_i),
    .reg_i     (io_addr_i[AW-1:0]),
    .wdata_i   (wdata_i),
    .mbus_i    (mbus_i),
    .mbus_o    (mbus_o),
    .mbus_oe_o (mbus_oe_o),
    .ale_o     (ale_o),
    .prd_o     (prd_o),
    .pwr_o     (pwr_o),
    .rdata_o   (rdata_o)
  );

  assign ack_no = (state != ST_ACK);

  // R1
  start_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> $past(req_i && cyc_type_i == CYC_IO
                    && io_addr_i[BA_W+AW-1:AW] == board_addr_i));

  // R5
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no && req_i) |=> !ack_no);

  // R8
  ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> !(ale_o || prd_o || pwr_o || mbus_oe_o));
endmodule

// File: tb/mux_bus_bridge_bench.sv
module mux_bus_bridge_bench;
  localparam int A_CYC = 2;
  localparam int D_CYC = 2;
  localparam logic [7:0] BOARD = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  cyc = 2'b00;
  logic        we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, mbus_o, mbus_i;
  logic        ack_n, oe, ale, prd, pwr;

  int checks = 0;
  int fails  = 0;

  logic [7:0] regs [256];
  logic [7:0] lat;

  always #4 clk = ~clk;

  mux_bus_bridge #(.ADDR_CYC(A_CYC), .DATA_CYC(D_CYC)) u_mux_bus_bridge (
    .clk_i(clk), .rst_ni(rst_n), .board_addr_i(BOARD), .req_i(req),
    .cyc_type_i(cyc), .we_i(we), .io_addr_i(io_addr), .wdata_i(wdata),
    .rdata_o(rdata), .ack_no(ack_n), .mbus_o(mbus_o), .mbus_oe_o(oe),
    .mbus_i(mbus_i), .ale_o(ale), .prd_o(prd), .pwr_o(pwr)
  );

  // peripheral model: register file on a shared bus
  always_ff @(posedge clk) begin
    if (ale && oe) lat <= mbus_o;
    if (pwr && oe) regs[lat] <= mbus_o;
  end
  assign mbus_i = prd ? regs[lat] : 8'h00;

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R7
    chk("R7 ack", ack_n, 1); chk("R7 strobes", {ale, prd, pwr}, 0); chk("R7 oe", oe, 0);
    rst_n = 1'b1;
  endtask

  // one full access, checked clock by clock
  task automatic t_access(input logic w, input logic [7:0] r, input logic [7:0] d,
                          input logic [7:0] exp_rd, input int hold);
    @(negedge clk);
    req = 1; cyc = 2'b10; we = w; io_addr = {BOARD, r}; wdata = d;
    for (int i = 1; i <= A_CYC; i++) begin
      @(negedge clk);
      chk("R2 oe", oe, 1); chk("R2 addr", mbus_o, r);
      chk("R2 ale", ale, (i == 1)); chk("R5 ack early", ack_n, 1);
    end
    for (int i = 1; i <= D_CYC; i++) begin
      @(negedge clk);
      if (w) begin
        chk("R3 oe", oe, 1); chk("R3 data", mbus_o, d); chk("R3 pwr", {pwr, prd}, 2'b10);
      end else begin
        chk("R4 oe", oe, 0); chk("R4 prd", {prd, pwr}, 2'b10);
      end
      chk("R8 ale", ale, 0); chk("R5 ack early", ack_n, 1);
    end
    @(negedge clk);
    chk("R5 ack edge", ack_n, 0);
    chk("R8 quiet", {ale, prd, pwr, oe}, 0);
    if (!w) chk("R4 rdata", rdata, exp_rd);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R5 ack hold", ack_n, 0);
    end
    req = 0;
    @(negedge clk);
    chk("R5 release", ack_n, 1);
  endtask

  task automatic t_ignored(input logic [1:0] c, input logic [7:0] ba, input logic [7:0] r);
    int seen = 0;
    @(negedge clk);
    req = 1; cyc = c; we = 1; io_addr = {ba, r}; wdata = 8'hEE;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ale || prd || pwr || oe || !ack_n) seen++;
    end
    // R6
    chk("R6 no activity", seen, 0);
    req = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'(i ^ 8'h3C);
    t_reset();
    t_access(1, 8'h10, 8'h5A, 8'h00, 0);
    t_access(0, 8'h10, 8'h00, 8'h5A, 2);          // R4 read back written value
    t_access(1, 8'hFF, 8'hC3, 8'h00, 3);
    t_access(0, 8'h07, 8'h00, 8'h07 ^ 8'h3C, 1);  // untouched register
    t_access(0, 8'hFF, 8'h00, 8'hC3, 0);
    t_ignored(2'b01, BOARD, 8'h10);               // R6 wrong cycle type
    t_ignored(2'b10, 8'hA4, 8'h10);               // R6 wrong board address
    t_access(0, 8'h10, 8'h00, 8'h5A, 0);          // R6 register unchanged
    // R1 back-to-back after release
    t_access(1, 8'h20, 8'h99, 8'h00, 0);
    t_access(0, 8'h20, 8'h00, 8'h99, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule